// File: doc/BRIEF.md
# Serial Command Port for a Dot-Matrix LCD Controller

This block is the host-facing front end of a character LCD controller. A host microcontroller talks to it over three wires: a strobe that frames each transfer, a shift clock that idles high, and a data line that is open-drain in the read direction. While the strobe is high, the first byte is a command and every later byte is data. Data bytes go to a store picked by the most recent data-setting command. The stores are a character-code RAM, an icon bit RAM, a user glyph RAM and an LED latch. A key-read command turns the window around, so that the port shifts key-matrix bytes back to the host.

Waveform generation and the built-in font are handled elsewhere. That logic reads the RAMs through registered read ports and uses the mode, status and LED registers. The host pins are sampled by the system clock, which must run at least four times faster than the shift clock. The data line is driven through an enable: while the enable is high, the pin is pulled low.

Top module: `lcd_cmd_port`

## Requirements
- R1: After reset the LED latch, mode register and status register are all zero and `sdo_oe` is low.
- R2: Input bits are taken MSB first on rising shift-clock edges. Read bits change after falling edges, and `sdo_oe` is high exactly while a 0 is being returned.
- R3: The first complete byte after the strobe rises is a command, classified by bits 7:6 (00 mode, 01 data setting, 10 address, 11 status). Every later byte in the same window is data.
- R4: Data-setting bits 2:0 select the target (000 character RAM, 001 icon RAM, 010 glyph RAM, 011 LED latch, 100 key read). Bit 3 = 0 advances the address after each character or icon write, and bit 3 = 1 holds it. Data-setting and address commands take effect as soon as their byte completes.
- R5: Address-command bits 4:0 load the address. The valid range is 0–24 for the character RAM, 0–7 for the icon RAM and 0–15 (a glyph code) for the glyph RAM. While the address is out of range, writes are dropped and the address does not advance.
- R6: A mode command takes effect at the strobe fall. When bits 5:0 differ from the held mode, the mode is replaced and status becomes 000100b (display forced off, LEDs enabled, scanning stopped). When they match, nothing changes.
- R7: A status command loads bits 5:0 into the status register at the strobe fall and not before. The fields are: 1:0 display control, 2 LED enable, 3 scan enable, 4 standby, 5 test.
- R8: An LED-latch write stores bits 3:0, with bit i driving LED i and 1 meaning lit.
- R9: A strobe fall discards a partly shifted byte and keeps completed bytes. `sdo_oe` is low whenever the strobe is low.
- R10: A glyph write places bits 4:0 in row bits 7:5 of the addressed code. Rows 0–6 are valid. The glyph address never advances.
- R11: After a key-read command, the window returns `key_in[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` in that order, then all ones. Bytes clocked in during a read window write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | Transfer strobe, high frames a window |
| sck | input | 1 | Shift clock, idles high |
| sdi | input | 1 | Serial data from host |
| key_in | input | 32 | Current key-matrix bits |
| sdo_oe | output | 1 | Pull data line low when high |
| text_raddr | input | 5 | Character RAM read address |
| text_rdata | output | 8 | Character RAM read data, one cycle later |
| icon_raddr | input | 3 | Icon RAM read address |
| icon_rdata | output | 8 | Icon RAM read data, one cycle later |
| glyph_raddr | input | 7 | Glyph read address {code, row} |
| glyph_rdata | output | 5 | Glyph row dots, one cycle later |
| led_on | output | 4 | LED latch |
| mode_reg | output | 6 | Held mode bits |
| status_reg | output | 6 | Status fields |

## Verification
The hardest behaviour to reach from the pins is an out-of-range write being dropped, because a dropped write leaves no mark by itself. The stimulus therefore makes any leak visible. It writes to glyph code 16, whose truncated index aliases code 0. It also sends two writes at character address 31, which would wrap to address 0 if the address advanced. In both cases a known value is placed at the aliased location beforehand and is checked afterwards. The key read is the other difficult case: the bench must clock a command and then run falling edges with no input, which requires the turnaround to line up with the byte boundary.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  typedef enum logic [1:0] {
    CL_MODE = 2'b00,
    CL_DATA = 2'b01,
    CL_ADDR = 2'b10,
    CL_STAT = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    TG_TEXT  = 3'd0,
    TG_ICON  = 3'd1,
    TG_GLYPH = 3'd2,
    TG_LED   = 3'd3,
    TG_KEY   = 3'd4
  } tgt_e;

  // status after a mode change: display forced off, LEDs on, scan stopped
  localparam logic [5:0] STAT_ON_MODE = 6'b000100;
endpackage

// File: rtl/lcp_rx.sv
module lcp_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb_pin,
  input  logic       sck_pin,
  input  logic       sdi_pin,
  output logic       stb_hi,
  output logic       stb_fall,
  output logic       sck_fall,
  output logic       byte_done,
  output logic       byte_first,
  output logic [7:0] byte_val
);
  logic [2:0] stb_p;
  logic [2:0] sck_p;
  logic [1:0] sdi_p;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic       seen;
  logic       sck_rise;
  logic       din;

  assign stb_hi   = stb_p[1];
  assign stb_fall = stb_p[2] & ~stb_p[1];
  assign sck_rise = ~sck_p[2] & sck_p[1];
  assign sck_fall = sck_p[2] & ~sck_p[1];
  assign din      = sdi_p[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_p      <= '0;
      sck_p      <= '1;
      sdi_p      <= '0;
      bit_cnt    <= '0;
      sh         <= '0;
      seen       <= 1'b0;
      byte_done  <= 1'b0;
      byte_first <= 1'b0;
      byte_val   <= '0;
    end else begin
      stb_p     <= {stb_p[1:0], stb_pin};
      sck_p     <= {sck_p[1:0], sck_pin};
      sdi_p     <= {sdi_p[0], sdi_pin};
      byte_done <= 1'b0;
      if (!stb_hi) begin
        bit_cnt <= '0;
        seen    <= 1'b0;
      end else if (sck_rise) begin
        sh      <= {sh[5:0], din};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done  <= 1'b1;
          byte_val   <= {sh, din};
          byte_first <= ~seen;
          seen       <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcp_keytx.sv
module lcp_keytx (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       active,
  input  logic       sck_fall,
  output logic       drv_low
);
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      drv_low <= 1'b0;
    end else begin
      if (!active)       drv_low <= 1'b0;
      else if (sck_fall) drv_low <= ~sh[7];
      if (load)          sh <= load_val;
      else if (!active)  sh <= '1;
      else if (sck_fall) sh <= {sh[6:0], 1'b1};
    end
  end
endmodule

// File: rtl/lcp_ram.sv
module lcp_ram #(
  parameter int W = 8,
  parameter int D = 32,
  localparam int AW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcd_cmd_port.sv
module lcd_cmd_port #(
  parameter int TEXT_DEPTH  = 25,
  parameter int ICON_DEPTH  = 8,
  parameter int GLYPH_CODES = 16,
  parameter int GLYPH_ROWS  = 7,
  parameter int LED_W       = 4,
  parameter int KEY_BYTES   = 4,
  parameter int CFG_W       = 6,
  localparam int ADDR_W = $clog2(TEXT_DEPTH),
  localparam int IAW    = $clog2(ICON_DEPTH),
  localparam int CODE_W = $clog2(GLYPH_CODES),
  localparam int GAW    = CODE_W + 3,
  localparam int DOT_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stb,
  input  logic                   sck,
  input  logic                   sdi,
  input  logic [8*KEY_BYTES-1:0] key_in,
  output logic                   sdo_oe,
  input  logic [ADDR_W-1:0]      text_raddr,
  output logic [7:0]             text_rdata,
  input  logic [IAW-1:0]         icon_raddr,
  output logic [7:0]             icon_rdata,
  input  logic [GAW-1:0]         glyph_raddr,
  output logic [DOT_W-1:0]       glyph_rdata,
  output logic [LED_W-1:0]       led_on,
  output logic [CFG_W-1:0]       mode_reg,
  output logic [CFG_W-1:0]       status_reg
);
  import lcp_pkg::*;

  localparam int RIW = $clog2(KEY_BYTES + 1);
  localparam logic [RIW-1:0]    RD_END     = RIW'(KEY_BYTES);
  localparam logic [ADDR_W-1:0] TEXT_LAST  = ADDR_W'(TEXT_DEPTH - 1);
  localparam logic [ADDR_W-1:0] ICON_LAST  = ADDR_W'(ICON_DEPTH - 1);
  localparam logic [ADDR_W-1:0] GLYPH_LAST = ADDR_W'(GLYPH_CODES - 1);
  localparam logic [2:0]        ROW_END    = 3'(GLYPH_ROWS);

  logic        stb_hi, stb_fall, sck_fall, byte_done, byte_first;
  logic [7:0]  byte_val;

  logic [2:0]        tgt_q;
  logic              fixed_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CFG_W-1:0]  mode_q, stat_q;
  logic [LED_W-1:0]  led_q;
  logic [7:0]        cmd_q;
  logic              cmd_ok;
  logic              rd_active;
  logic [RIW-1:0]    rd_idx, sel_idx;
  logic [7:0]        ld_val;
  logic              load, is_rd_cmd;
  logic              data_wr, addr_ok, bump;
  logic              text_we, icon_we, glyph_we;

  lcp_rx u_rx (
    .clk, .rst,
    .stb_pin(stb), .sck_pin(sck), .sdi_pin(sdi),
    .stb_hi, .stb_fall, .sck_fall,
    .byte_done, .byte_first, .byte_val
  );

  // command-byte classification
  assign is_rd_cmd = (byte_val[7:6] == CL_DATA) && (byte_val[2:0] == TG_KEY);
  assign data_wr   = byte_done & ~byte_first & ~rd_active;

  always_comb begin
    case (tgt_q)
      TG_TEXT:  addr_ok = (addr_q <= TEXT_LAST);
      TG_ICON:  addr_ok = (addr_q <= ICON_LAST);
      TG_GLYPH: addr_ok = (addr_q <= GLYPH_LAST);
      default:  addr_ok = 1'b1;
    endcase
  end

  assign text_we  = data_wr && (tgt_q == TG_TEXT)  && addr_ok;
  assign icon_we  = data_wr && (tgt_q == TG_ICON)  && addr_ok;
  assign glyph_we = data_wr && (tgt_q == TG_GLYPH) && addr_ok
                    && (byte_val[7:5] < ROW_END);
  assign bump     = (text_we || icon_we) && !fixed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q     <= TG_TEXT;
      fixed_q   <= 1'b0;
      addr_q    <= '0;
      mode_q    <= '0;
      stat_q    <= '0;
      led_q     <= '0;
      cmd_q     <= '0;
      cmd_ok    <= 1'b0;
      rd_active <= 1'b0;
      rd_idx    <= '0;
    end else begin
      if (!stb_hi) rd_active <= 1'b0;
      if (byte_done && byte_first) begin
        cmd_q  <= byte_val;
        cmd_ok <= 1'b1;
        case (byte_val[7:6])
          CL_DATA: begin
            tgt_q   <= byte_val[2:0];
            fixed_q <= byte_val[3];
            if (is_rd_cmd) begin
              rd_active <= 1'b1;
              rd_idx    <= RIW'(1);
            end
          end
          CL_ADDR: addr_q <= byte_val[ADDR_W-1:0];
          default: ;
        endcase
      end else if (byte_done && rd_active && rd_idx != RD_END) begin
        rd_idx <= rd_idx + RIW'(1);
      end
      if (data_wr) begin
        if (tgt_q == TG_LED) led_q <= byte_val[LED_W-1:0];
        if (bump) addr_q <= addr_q + ADDR_W'(1);
      end
      if (stb_fall && cmd_ok) begin
        cmd_ok <= 1'b0;
        if (cmd_q[7:6] == CL_MODE && cmd_q[CFG_W-1:0] != mode_q) begin
          mode_q <= cmd_q[CFG_W-1:0];
          stat_q <= STAT_ON_MODE;
        end
        if (cmd_q[7:6] == CL_STAT) stat_q <= cmd_q[CFG_W-1:0];
      end
    end
  end

  // key byte selection for the read shifter
  assign load    = byte_done && ((byte_first && is_rd_cmd) || (rd_active && !byte_first));
  assign sel_idx = byte_first ? '0 : rd_idx;

  always_comb begin
    ld_val = '1;
    for (int k = 0; k < KEY_BYTES; k++) begin
      if (sel_idx == RIW'(k)) ld_val = key_in[8*(KEY_BYTES-1-k) +: 8];
    end
  end

  lcp_keytx u_tx (
    .clk, .rst,
    .load, .load_val(ld_val),
    .active(rd_active & stb_hi),
    .sck_fall,
    .drv_low(sdo_oe)
  );

  lcp_ram #(.W(8), .D(TEXT_DEPTH)) u_text (
    .clk, .we(text_we), .waddr(addr_q), .wdata(byte_val),
    .raddr(text_raddr), .rdata(text_rdata)
  );

  lcp_ram #(.W(8), .D(ICON_DEPTH)) u_icon (
    .clk, .we(icon_we), .waddr(addr_q[IAW-1:0]), .wdata(byte_val),
    .raddr(icon_raddr), .rdata(icon_rdata)
  );

  lcp_ram #(.W(DOT_W), .D(1 << GAW)) u_glyph (
    .clk, .we(glyph_we), .waddr({addr_q[CODE_W-1:0], byte_val[7:5]}),
    .wdata(byte_val[DOT_W-1:0]),
    .raddr(glyph_raddr), .rdata(glyph_rdata)
  );

  assign led_on     = led_q;
  assign mode_reg   = mode_q;
  assign status_reg = stat_q;
endmodule

// File: rtl/lcd_cmd_port_chk.sv
module lcd_cmd_port_chk #(
  parameter int ADDR_W = 5,
  parameter int CFG_W  = 6,
  parameter int LED_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stb_hi,
  input logic              stb_fall,
  input logic              sck_fall,
  input logic              byte_done,
  input logic              data_wr,
  input logic              addr_ok,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CFG_W-1:0]  mode_q,
  input logic [CFG_W-1:0]  stat_q,
  input logic [LED_W-1:0]  led_q,
  input logic              sdo_oe
);
  assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(sck_fall));

  assert_blocked_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !addr_ok) |=> $stable(addr_q));

  assert_mode_at_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !stb_fall |=> $stable(mode_q));

  assert_status_at_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !stb_fall |=> $stable(stat_q));

  assert_led_on_byte_R8: assert property (@(posedge clk) disable iff (rst)
    !byte_done |=> $stable(led_q));

  assert_oe_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !stb_hi |=> !sdo_oe);
endmodule

bind lcd_cmd_port lcd_cmd_port_chk #(
  .ADDR_W(ADDR_W), .CFG_W(CFG_W), .LED_W(LED_W)
) u_chk (
  .clk(clk), .rst(rst), .stb_hi(stb_hi), .stb_fall(stb_fall),
  .sck_fall(sck_fall), .byte_done(byte_done), .data_wr(data_wr),
  .addr_ok(addr_ok), .addr_q(addr_q), .mode_q(mode_q), .stat_q(stat_q),
  .led_q(led_q), .sdo_oe(sdo_oe)
);

// File: tb/lcd_cmd_port_test.sv
module lcd_cmd_port_test;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int K_TEXT = 0, K_ICON = 1, K_GLYPH = 2, K_LED = 3,
                 K_MODE = 4, K_STAT = 5, K_OE = 6, K_KEY = 7;

  logic clk = 1'b0, rst = 1'b1, stb = 1'b0, sck = 1'b1, sdi = 1'b1;
  logic [31:0] key_in = '0;
  logic        sdo_oe;
  logic [4:0]  text_raddr = '0;
  logic [7:0]  text_rdata;
  logic [2:0]  icon_raddr = '0;
  logic [7:0]  icon_rdata;
  logic [6:0]  glyph_raddr = '0;
  logic [4:0]  glyph_rdata;
  logic [3:0]  led_on;
  logic [5:0]  mode_reg, status_reg;

  always #(CLK_NS/2) clk = ~clk;

  lcd_cmd_port uut (
    .clk, .rst, .stb, .sck, .sdi, .key_in, .sdo_oe,
    .text_raddr, .text_rdata, .icon_raddr, .icon_rdata,
    .glyph_raddr, .glyph_rdata, .led_on, .mode_reg, .status_reg
  );

  typedef struct {
    int    kind;
    int    idx;
    int    exp;
    int    got;
    string tag;
  } item_t;

  item_t sb[$];
  bit    mon_busy = 1'b0;
  bit    done = 1'b0;
  int    checks = 0, fails = 0;

  task automatic expect_val(input int kind, input int idx, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.got = 0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_key(input int got, input int exp, input string tag);
    item_t it;
    it.kind = K_KEY; it.idx = 0; it.exp = exp; it.got = got; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    wait (sb.size() == 0 && !mon_busy);
    @(negedge clk);
  endtask

  // scoreboard monitor: pops expected items and samples the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        item_t it;
        mon_busy = 1'b1;
        it = sb.pop_front();
        case (it.kind)
          K_TEXT:  begin text_raddr  = 5'(it.idx); repeat (2) @(negedge clk); it.got = int'(text_rdata);  end
          K_ICON:  begin icon_raddr  = 3'(it.idx); repeat (2) @(negedge clk); it.got = int'(icon_rdata);  end
          K_GLYPH: begin glyph_raddr = 7'(it.idx); repeat (2) @(negedge clk); it.got = int'(glyph_rdata); end
          K_LED:   it.got = int'(led_on);
          K_MODE:  it.got = int'(mode_reg);
          K_STAT:  it.got = int'(status_reg);
          K_OE:    it.got = int'(sdo_oe);
          default: ;
        endcase
        checks++;
        if (it.got != it.exp) begin
          fails++;
          $display("FAIL %s got=%0h exp=%0h", it.tag, it.got, it.exp);
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic win_open();
    @(negedge clk); stb = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic win_close();
    repeat (HALF) @(negedge clk);
    stb = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sck = 1'b0; sdi = b[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    put_bits(b, 8);
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      v[i] = sdo_oe ? 1'b0 : 1'b1;
      sck = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic send1(input logic [7:0] a);
    win_open(); put_byte(a); win_close();
  endtask

  task automatic send2(input logic [7:0] a, input logic [7:0] b);
    win_open(); put_byte(a); put_byte(b); win_close();
  endtask

  task automatic send3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    win_open(); put_byte(a); put_byte(b); put_byte(c); win_close();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_val(K_LED, 0, 0, "R1 led after reset");
    expect_val(K_MODE, 0, 0, "R1 mode after reset");
    expect_val(K_STAT, 0, 0, "R1 status after reset");
    expect_val(K_OE, 0, 0, "R1 data line released");
    settle();

    // R3 R4 character RAM with increment, address and data in one window
    send1(8'h40);
    send3(8'h83, 8'hA1, 8'hA2);
    expect_val(K_TEXT, 3, 'hA1, "R3 text[3]");
    expect_val(K_TEXT, 4, 'hA2, "R4 text[4] after increment");
    settle();

    // R4 fixed address
    send1(8'h40);
    send3(8'h85, 8'h55, 8'h66);
    send1(8'h48);
    send3(8'h85, 8'h11, 8'h22);
    expect_val(K_TEXT, 5, 'h22, "R4 fixed address overwrite");
    expect_val(K_TEXT, 6, 'h66, "R4 fixed address no advance");
    settle();

    // R5 range limits on the character RAM
    send1(8'h40);
    send2(8'h80, 8'h10);
    send3(8'h98, 8'h77, 8'h88);
    send3(8'h9F, 8'hEE, 8'hEE);
    expect_val(K_TEXT, 24, 'h77, "R5 last valid address");
    expect_val(K_TEXT, 0, 'h10, "R5 out of range write blocked");
    settle();

    // R4 icon RAM
    send1(8'h41);
    send3(8'h80, 8'h3C, 8'h99);
    send2(8'h87, 8'h5A);
    expect_val(K_ICON, 0, 'h3C, "R4 icon[0]");
    expect_val(K_ICON, 1, 'h99, "R4 icon[1] increment");
    expect_val(K_ICON, 7, 'h5A, "R4 icon[7]");
    settle();

    // R10 glyph rows, no advance; R5 code 16 blocked
    send1(8'h42);
    send2(8'h80, 8'h11);
    win_open(); put_byte(8'h83); put_byte(8'h55); put_byte(8'h0A); put_byte(8'h2F); win_close();
    send2(8'h90, 8'h07);
    expect_val(K_GLYPH, 3*8+2, 'h15, "R10 glyph code3 row2");
    expect_val(K_GLYPH, 3*8+0, 'h0A, "R10 glyph code3 row0 no advance");
    expect_val(K_GLYPH, 3*8+1, 'h0F, "R10 glyph code3 row1");
    expect_val(K_GLYPH, 0, 'h11, "R5 glyph code 16 blocked");
    settle();

    // R8 LED latch, R3 data setting then data in one window
    send2(8'h43, 8'hF5);
    expect_val(K_LED, 0, 'h5, "R8 led low nibble");
    settle();

    // R7 status applied only at strobe fall
    win_open(); put_byte(8'hCE);
    repeat (6) @(negedge clk);
    expect_val(K_STAT, 0, 0, "R7 status held until strobe fall");
    settle();
    win_close();
    expect_val(K_STAT, 0, 'h0E, "R7 status after strobe fall");
    settle();

    // R6 mode command
    send1(8'h05);
    expect_val(K_MODE, 0, 'h05, "R6 mode loaded");
    expect_val(K_STAT, 0, 'h04, "R6 status forced");
    settle();
    send1(8'hCB);
    send1(8'h05);
    expect_val(K_STAT, 0, 'h0B, "R6 same mode leaves status");
    expect_val(K_MODE, 0, 'h05, "R6 same mode kept");
    settle();
    send1(8'h06);
    expect_val(K_MODE, 0, 'h06, "R6 new mode");
    expect_val(K_STAT, 0, 'h04, "R6 status forced again");
    settle();

    // R9 partial bytes discarded
    win_open(); put_byte(8'h43); put_byte(8'h0A); put_bits(8'h0F, 5); win_close();
    expect_val(K_LED, 0, 'hA, "R9 completed byte kept");
    settle();
    win_open(); put_byte(8'h43); put_bits(8'hF0, 7); win_close();
    expect_val(K_LED, 0, 'hA, "R9 partial data byte dropped");
    settle();
    win_open(); put_bits(8'hC3, 4); win_close();
    expect_val(K_STAT, 0, 'h04, "R9 partial command dropped");
    settle();

    // R11 R2 key read
    key_in = 32'hA53C0F81;
    win_open(); put_byte(8'h44);
    repeat (20) @(negedge clk);
    get_byte(rb); expect_key(int'(rb), 'hA5, "R11 key byte 0");
    get_byte(rb); expect_key(int'(rb), 'h3C, "R2 key byte 1");
    get_byte(rb); expect_key(int'(rb), 'h0F, "R11 key byte 2");
    get_byte(rb); expect_key(int'(rb), 'h81, "R11 key byte 3");
    get_byte(rb); expect_key(int'(rb), 'hFF, "R11 released after last byte");
    win_close();
    expect_val(K_OE, 0, 0, "R9 line released after window");
    expect_val(K_LED, 0, 'hA, "R11 read window writes nothing");
    settle();

    done = 1'b1;
    report();
    $finish;
  end
endmodule